// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block holds the control and status state of the seven endpoints (0 to 6) of a USB device function. For every token it receives from the serial interface engine, it picks the handshake reply. A processor configures each endpoint and arms or clears its flags through a small register port with write strobe, address, endpoint select and write data. The current value of the selected register is always visible on a read bus.

Token events arrive on a one-cycle strobe that carries a token kind and an endpoint number. The reply is registered and appears on the cycle after the token. The reply is one of four kinds: send data (with the DATA0/DATA1 parity), ACK, NAK or STALL. When a reply is not allowed, no reply is given. Two more strobes come from the engine: one reports that the host acknowledged a transmitted packet, and the other reports that a packet has finished transmitting. From these the block clears the transmit-ready flag and steps the data toggle, following the endpoint's transfer type. Ping-pong enables are only held and read back.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: After reset, every register reads 0 and no handshake is issued.
- R2: Register address 0 is the endpoint configuration: bit 0 enable (1 = enabled), bit 1 direction (1 = IN, 0 = OUT), bit 2 data toggle (1 = DATA1), bits 4:3 type (00 control, 01 isochronous, 10 bulk, 11 interrupt). Bits 7:5 read 0. Selecting endpoint 7 reads 0, and writes to it are dropped.
- R3: Register address 2 holds one ping-pong enable per endpoint in bits 0..6, independent of the endpoint select. Bit 7 always reads 0. Address 3 reads 0 and ignores writes.
- R4: A token to a disabled endpoint, or to endpoint 7, gives no handshake and changes no flag.
- R5: An IN or OUT token to an enabled endpoint with force-stall set is answered with STALL, ahead of any data. The stall-sent flag of that endpoint is set by the same clock edge that issues the reply.
- R6: An IN token to an enabled, non-stalled endpoint is answered with data when transmit-ready is set, with hs_odd equal to the toggle bit. When transmit-ready is clear, it is answered with NAK.
- R7: A host ACK to a non-isochronous endpoint with transmit-ready set clears transmit-ready and inverts the toggle. In any other case the ACK has no effect.
- R8: On an isochronous endpoint, the transmit-done strobe clears transmit-ready whether or not an ACK is seen. A host ACK changes nothing, and the toggle is never changed by traffic. Transmit-done has no effect on other types.
- R9: A SETUP token to an enabled control endpoint is answered with ACK, sets setup-received and sets the toggle to 1. A SETUP token to any other endpoint type gets no reply and sets no flag.
- R10: The direction bit is ignored on control endpoints. On other types, an IN token to an OUT endpoint, or an OUT token to an IN endpoint, gets no reply.
- R11: An OUT token to an enabled, non-stalled endpoint whose direction matches is answered with ACK. If that endpoint is isochronous, it gets no reply.
- R12: Register address 1 is the endpoint status. Bit 0 is transmit-ready: writing 1 sets it and writing 0 leaves it. Bit 1 is force-stall and takes the written value. Bit 2 is stall-sent and bit 3 is setup-received; both are cleared by writing 1. Bits 7:4 read 0.
- R13: The reply appears exactly one cycle after its token, with hs_ep equal to the token's endpoint. hs_kind encodes 00 data, 01 ACK, 10 NAK, 11 STALL. While hs_valid is low, hs_kind, hs_ep and hs_odd are 0. Token kind encodes 01 OUT, 10 IN, 11 SETUP; 00 is no token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 config, 1 status, 2 ping-pong, 3 unused |
| cfg_ep | input | 3 | Endpoint select for read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register (combinational) |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token kind |
| tok_ep | input | 3 | Token endpoint |
| ack_valid | input | 1 | Host ACK seen for a transmitted packet |
| ack_ep | input | 3 | Endpoint of that ACK |
| txdone_valid | input | 1 | Packet transmission finished |
| txdone_ep | input | 3 | Endpoint of that packet |
| hs_valid | output | 1 | Handshake reply valid |
| hs_kind | output | 2 | Reply kind |
| hs_ep | output | 3 | Endpoint of the reply |
| hs_odd | output | 1 | Data parity of a data reply (1 = DATA1) |

## Verification
The properties assume that a token, an ACK or a transmit-done strobe for an endpoint never arrives in the same cycle as a processor write, or as another engine strobe. Under that assumption, each flag update can be credited to one cause. The bench keeps to this by issuing exactly one operation per cycle, whether in its directed sequences or in its random mix. The random mix also draws endpoint 7 and all token kinds, including the null kind.

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl #(
  parameter int N_EP = 7,
  localparam int EPW = (N_EP > 1) ? $clog2(N_EP) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_addr,
  input  logic [EPW-1:0] cfg_ep,
  input  logic [7:0]     cfg_wdata,
  output logic [7:0]     cfg_rdata,
  input  logic           tok_valid,
  input  logic [1:0]     tok_kind,
  input  logic [EPW-1:0] tok_ep,
  input  logic           ack_valid,
  input  logic [EPW-1:0] ack_ep,
  input  logic           txdone_valid,
  input  logic [EPW-1:0] txdone_ep,
  output logic           hs_valid,
  output logic [1:0]     hs_kind,
  output logic [EPW-1:0] hs_ep,
  output logic           hs_odd
);
  localparam logic [EPW-1:0] LAST = EPW'(N_EP - 1);
  localparam logic [1:0] T_CTRL = 2'd0, T_ISO = 2'd1;
  localparam logic [1:0] K_OUT = 2'b01, K_IN = 2'b10, K_SETUP = 2'b11;
  localparam logic [1:0] H_DATA = 2'd0, H_ACK = 2'd1, H_NAK = 2'd2, H_STALL = 2'd3;

  logic [N_EP-1:0] en_q, dir_q, tog_q, stall_q, txrdy_q, ssent_q, setup_q, pp_q;
  logic [N_EP-1:0][1:0] typ_q;

  logic rsp_v;
  logic [1:0] rsp_k;

  wire tk_ok     = tok_valid && (tok_kind != 2'b00) && (tok_ep <= LAST);
  wire [1:0] tk_typ = typ_q[tok_ep];
  wire tk_ctrl   = (tk_typ == T_CTRL);
  wire tk_dir_ok = tk_ctrl || ((tok_kind == K_IN) == dir_q[tok_ep]);
  wire setup_hit = rsp_v && (tok_kind == K_SETUP);

  always_comb begin
    rsp_v = 1'b0;
    rsp_k = H_NAK;
    if (tk_ok && en_q[tok_ep]) begin
      if (tok_kind == K_SETUP) begin
        if (tk_ctrl) begin
          rsp_v = 1'b1;
          rsp_k = H_ACK;
        end
      end else if (tk_dir_ok) begin
        rsp_v = 1'b1;
        if (stall_q[tok_ep])       rsp_k = H_STALL;
        else if (tok_kind == K_IN) rsp_k = txrdy_q[tok_ep] ? H_DATA : H_NAK;
        else if (tk_typ == T_ISO)  rsp_v = 1'b0;
        else                       rsp_k = H_ACK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; dir_q <= '0; tog_q <= '0; stall_q <= '0; txrdy_q <= '0;
      ssent_q <= '0; setup_q <= '0; pp_q <= '0; typ_q <= '0;
      hs_valid <= 1'b0; hs_kind <= 2'd0; hs_ep <= '0; hs_odd <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == 2'd2) pp_q <= cfg_wdata[N_EP-1:0];
      for (int i = 0; i < N_EP; i++) begin
        if (cfg_we && cfg_ep == EPW'(i)) begin
          if (cfg_addr == 2'd0) begin
            en_q[i]  <= cfg_wdata[0];
            dir_q[i] <= cfg_wdata[1];
            tog_q[i] <= cfg_wdata[2];
            typ_q[i] <= cfg_wdata[4:3];
          end else if (cfg_addr == 2'd1) begin
            txrdy_q[i] <= txrdy_q[i] | cfg_wdata[0];
            stall_q[i] <= cfg_wdata[1];
            ssent_q[i] <= ssent_q[i] & ~cfg_wdata[2];
            setup_q[i] <= setup_q[i] & ~cfg_wdata[3];
          end
        end
        if (rsp_v && tok_ep == EPW'(i)) begin
          if (rsp_k == H_STALL) ssent_q[i] <= 1'b1;
          if (setup_hit) begin
            setup_q[i] <= 1'b1;
            tog_q[i]   <= 1'b1;
          end
        end
        if (ack_valid && ack_ep == EPW'(i) && txrdy_q[i] && typ_q[i] != T_ISO) begin
          txrdy_q[i] <= 1'b0;
          tog_q[i]   <= ~tog_q[i];
        end
        if (txdone_valid && txdone_ep == EPW'(i) && typ_q[i] == T_ISO)
          txrdy_q[i] <= 1'b0;
      end
      hs_valid <= rsp_v;
      hs_kind  <= rsp_v ? rsp_k : 2'd0;
      hs_ep    <= rsp_v ? tok_ep : '0;
      hs_odd   <= rsp_v && (rsp_k == H_DATA) && tog_q[tok_ep];
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    case (cfg_addr)
      2'd0: if (cfg_ep <= LAST)
              cfg_rdata = {3'b000, typ_q[cfg_ep], tog_q[cfg_ep], dir_q[cfg_ep], en_q[cfg_ep]};
      2'd1: if (cfg_ep <= LAST)
              cfg_rdata = {4'h0, setup_q[cfg_ep], ssent_q[cfg_ep], stall_q[cfg_ep], txrdy_q[cfg_ep]};
      2'd2: cfg_rdata = 8'(pp_q);
      default: cfg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/usb_ep_hs_ctrl_chk.sv
module usb_ep_hs_ctrl_chk #(
  parameter int N_EP = 7,
  localparam int EPW = (N_EP > 1) ? $clog2(N_EP) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic                 tok_valid,
  input logic [1:0]           tok_kind,
  input logic [EPW-1:0]       tok_ep,
  input logic                 ack_valid,
  input logic [EPW-1:0]       ack_ep,
  input logic                 txdone_valid,
  input logic [EPW-1:0]       txdone_ep,
  input logic                 hs_valid,
  input logic [1:0]           hs_kind,
  input logic [EPW-1:0]       hs_ep,
  input logic                 hs_odd,
  input logic [N_EP-1:0]      en_q,
  input logic [N_EP-1:0]      dir_q,
  input logic [N_EP-1:0]      tog_q,
  input logic [N_EP-1:0]      stall_q,
  input logic [N_EP-1:0]      txrdy_q,
  input logic [N_EP-1:0]      ssent_q,
  input logic [N_EP-1:0]      setup_q,
  input logic [N_EP-1:0][1:0] typ_q
);
  localparam logic [EPW-1:0] LAST = EPW'(N_EP - 1);

  wire t_in    = tok_valid && tok_ep <= LAST && tok_kind == 2'b10;
  wire t_inout = tok_valid && tok_ep <= LAST && (tok_kind == 2'b10 || tok_kind == 2'b01);
  wire t_setup = tok_valid && tok_ep <= LAST && tok_kind == 2'b11;
  wire t_match = typ_q[tok_ep] == 2'd0 || (tok_kind == 2'b10) == dir_q[tok_ep];

  p_disabled_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_ep <= LAST && !en_q[tok_ep] |=> !hs_valid);

  p_stall_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    t_inout && en_q[tok_ep] && stall_q[tok_ep] && t_match |=> hs_valid && hs_kind == 2'd3);

  p_stall_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid && hs_kind == 2'd3 |-> ssent_q[hs_ep]);

  p_data_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    t_in && en_q[tok_ep] && !stall_q[tok_ep] && t_match && txrdy_q[tok_ep]
    |=> hs_valid && hs_kind == 2'd0 && hs_odd == $past(tog_q[tok_ep]));

  p_nak_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    t_in && en_q[tok_ep] && !stall_q[tok_ep] && t_match && !txrdy_q[tok_ep]
    |=> hs_valid && hs_kind == 2'd2);

  p_ack_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ep <= LAST && txrdy_q[ack_ep] && typ_q[ack_ep] != 2'd1 && !cfg_we && !tok_valid
    |=> !txrdy_q[$past(ack_ep)] && tog_q[$past(ack_ep)] != $past(tog_q[ack_ep]));

  p_iso_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txdone_valid && txdone_ep <= LAST && typ_q[txdone_ep] == 2'd1 && !cfg_we && !tok_valid && !ack_valid
    |=> !txrdy_q[$past(txdone_ep)] && $stable(tog_q));

  p_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t_setup && en_q[tok_ep] && typ_q[tok_ep] == 2'd0 && !cfg_we
    |=> hs_valid && hs_kind == 2'd1 && setup_q[$past(tok_ep)] && tog_q[$past(tok_ep)]);

  p_reply_echo_r13: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(tok_valid) && hs_ep == $past(tok_ep));

  p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_valid |-> hs_kind == 2'd0 && hs_ep == '0 && !hs_odd);
endmodule

bind usb_ep_hs_ctrl usb_ep_hs_ctrl_chk #(.N_EP(N_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
  .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_ep(tok_ep),
  .ack_valid(ack_valid), .ack_ep(ack_ep),
  .txdone_valid(txdone_valid), .txdone_ep(txdone_ep),
  .hs_valid(hs_valid), .hs_kind(hs_kind), .hs_ep(hs_ep), .hs_odd(hs_odd),
  .en_q(en_q), .dir_q(dir_q), .tog_q(tog_q), .stall_q(stall_q),
  .txrdy_q(txrdy_q), .ssent_q(ssent_q), .setup_q(setup_q), .typ_q(typ_q)
);

// File: tb/usb_ep_hs_ctrl_tb.sv
`timescale 1ns/1ps
module usb_ep_hs_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [2:0] cfg_ep = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic tok_valid = 1'b0;
  logic [1:0] tok_kind = '0;
  logic [2:0] tok_ep = '0;
  logic ack_valid = 1'b0;
  logic [2:0] ack_ep = '0;
  logic txdone_valid = 1'b0;
  logic [2:0] txdone_ep = '0;
  logic hs_valid, hs_odd;
  logic [1:0] hs_kind;
  logic [2:0] hs_ep;

  always #10 clk = ~clk;

  usb_ep_hs_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_ep(cfg_ep),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tok_ep(tok_ep), .ack_valid(ack_valid), .ack_ep(ack_ep), .txdone_valid(txdone_valid),
    .txdone_ep(txdone_ep), .hs_valid(hs_valid), .hs_kind(hs_kind), .hs_ep(hs_ep), .hs_odd(hs_odd)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  bit m_en[7], m_dir[7], m_tog[7], m_stall[7], m_txr[7], m_ss[7], m_su[7], m_pp[7];
  int m_typ[7];
  bit m_hv, m_ho;
  int m_hk, m_he;

  always @(posedge clk) begin
    int e, kind, reply;
    bit give, par;
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) begin
        m_en[i] = 0; m_dir[i] = 0; m_tog[i] = 0; m_stall[i] = 0; m_txr[i] = 0;
        m_ss[i] = 0; m_su[i] = 0; m_pp[i] = 0; m_typ[i] = 0;
      end
      m_hv = 0; m_hk = 0; m_he = 0; m_ho = 0;
    end else begin
      e = int'(tok_ep); kind = int'(tok_kind);
      give = 0; reply = 0; par = 0;
      if (tok_valid && kind != 0 && e < 7 && m_en[e]) begin
        if (kind == 3) begin
          if (m_typ[e] == 0) begin give = 1; reply = 1; end
        end else if (m_typ[e] == 0 || (kind == 2 && m_dir[e]) || (kind == 1 && !m_dir[e])) begin
          if (m_stall[e]) begin give = 1; reply = 3; end
          else if (kind == 2) begin give = 1; reply = m_txr[e] ? 0 : 2; par = m_txr[e] & m_tog[e]; end
          else if (m_typ[e] != 1) begin give = 1; reply = 1; end
        end
      end
      if (cfg_we && cfg_addr == 2 ) for (int i = 0; i < 7; i++) m_pp[i] = cfg_wdata[i];
      if (cfg_we && cfg_ep < 7) begin
        if (cfg_addr == 0) begin
          m_en[cfg_ep] = cfg_wdata[0]; m_dir[cfg_ep] = cfg_wdata[1];
          m_tog[cfg_ep] = cfg_wdata[2]; m_typ[cfg_ep] = int'(cfg_wdata[4:3]);
        end else if (cfg_addr == 1) begin
          if (cfg_wdata[0]) m_txr[cfg_ep] = 1;
          m_stall[cfg_ep] = cfg_wdata[1];
          if (cfg_wdata[2]) m_ss[cfg_ep] = 0;
          if (cfg_wdata[3]) m_su[cfg_ep] = 0;
        end
      end
      if (give && reply == 3) m_ss[e] = 1;
      if (give && kind == 3) begin m_su[e] = 1; m_tog[e] = 1; end
      if (ack_valid && ack_ep < 7 && m_txr[ack_ep] && m_typ[ack_ep] != 1) begin
        m_txr[ack_ep] = 0; m_tog[ack_ep] = !m_tog[ack_ep];
      end
      if (txdone_valid && txdone_ep < 7 && m_typ[txdone_ep] == 1) m_txr[txdone_ep] = 0;
      m_hv = give; m_hk = give ? reply : 0; m_he = give ? e : 0; m_ho = par;
    end
  end

  function automatic int model_read();
    int a = int'(cfg_addr);
    int p = int'(cfg_ep);
    int r = 0;
    if (a == 0 && p < 7) r = (m_typ[p] << 3) | (m_tog[p] << 2) | (m_dir[p] << 1) | m_en[p];
    else if (a == 1 && p < 7) r = (m_su[p] << 3) | (m_ss[p] << 2) | (m_stall[p] << 1) | m_txr[p];
    else if (a == 2) for (int i = 0; i < 7; i++) r |= m_pp[i] << i;
    return r;
  endfunction

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      cmp("hs_valid", int'(hs_valid), int'(m_hv));
      cmp("hs_kind", int'(hs_kind), m_hk);
      cmp("hs_ep", int'(hs_ep), m_he);
      cmp("hs_odd", int'(hs_odd), int'(m_ho));
      cmp("cfg_rdata", int'(cfg_rdata), model_read());
    end
    cfg_we = 0; tok_valid = 0; ack_valid = 0; txdone_valid = 0;
  endtask

  task automatic wr(int a, int ep, int d);
    cfg_we = 1; cfg_addr = 2'(a); cfg_ep = 3'(ep); cfg_wdata = 8'(d); tick();
  endtask
  task automatic rd(int a, int ep);
    cfg_addr = 2'(a); cfg_ep = 3'(ep); tick();
  endtask
  task automatic tok(int k, int ep);
    tok_valid = 1; tok_kind = 2'(k); tok_ep = 3'(ep); tick(); tick();
  endtask
  task automatic ack(int ep);
    ack_valid = 1; ack_ep = 3'(ep); tick();
  endtask
  task automatic done(int ep);
    txdone_valid = 1; txdone_ep = 3'(ep); tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    for (int a = 0; a < 4; a++) for (int p = 0; p < 8; p++) rd(a, p);
    cur_req = "R2";
    wr(0, 1, 8'h13); rd(0, 1);
    wr(0, 2, 8'hFF); rd(0, 2);
    wr(0, 7, 8'hFF); rd(0, 7);
    cur_req = "R3";
    wr(2, 5, 8'hFF); rd(2, 0); wr(3, 0, 8'hFF); rd(3, 0); wr(2, 0, 8'h2A); rd(2, 6);
    cur_req = "R12";
    wr(1, 3, 8'hFF); rd(1, 3); wr(1, 3, 8'h00); rd(1, 3);
    cur_req = "R4";
    wr(1, 4, 8'h01); tok(2, 4); rd(1, 4); tok(2, 7);
    cur_req = "R6";
    tok(2, 1); wr(1, 1, 8'h01); tok(2, 1);
    cur_req = "R7";
    ack(1); rd(0, 1); ack(1); rd(0, 1); wr(1, 1, 8'h01); tok(2, 1);
    cur_req = "R5";
    wr(1, 1, 8'h03); tok(2, 1); rd(1, 1); wr(1, 1, 8'h04); rd(1, 1); tok(2, 1);
    cur_req = "R10";
    wr(0, 0, 8'h01); tok(1, 1); tok(2, 0); tok(1, 0);
    cur_req = "R11";
    wr(0, 5, 8'h11); tok(1, 5); wr(0, 6, 8'h09); tok(1, 6);
    cur_req = "R8";
    wr(0, 6, 8'h0F); wr(1, 6, 8'h01); ack(6); rd(1, 6); tok(2, 6); done(6); rd(1, 6); rd(0, 6);
    cur_req = "R9";
    tok(3, 0); rd(1, 0); rd(0, 0); wr(1, 0, 8'h08); rd(1, 0); tok(3, 1); rd(1, 1);
    cur_req = "R13";
    for (int n = 0; n < 2000; n++) begin
      int op = $urandom_range(0, 5);
      int ep = $urandom_range(0, 7);
      case (op)
        0: wr($urandom_range(0, 3), ep, $urandom_range(0, 255));
        1, 2: begin tok_valid = 1; tok_kind = 2'($urandom_range(0, 3)); tok_ep = 3'(ep); tick(); end
        3: ack(ep);
        4: done(ep);
        default: rd($urandom_range(0, 3), ep);
      endcase
    end
    tick();
    summary();
    $finish;
  end
endmodule